// File: doc/BRIEF.md
# Buffer Descriptor Ring Manager

This block holds the buffer descriptors of a frame engine in one shared storage of 128 two-word entries. A movable boundary splits it: entries below the boundary form the transmit ring and the entries from the boundary up form the receive ring. The block tracks the current transmit and receive entries. It decides when a transmission may begin and when an incoming frame may be taken. When a transfer completes, it retires the entry by writing status and length back, advances the ring index, and raises a one-cycle interrupt request if the entry asked for one.

Software fills descriptors through a word-wide host port that covers 1 KB. Moving frame data is left to a separate engine. That engine receives a start pulse carrying the frame length, buffer pointer and pad request. It reports completion with a single-cycle done pulse. On the receive side, a level shows that a frame may be accepted, and a done pulse carries the received length and the address-miss flag.

Top module: `bd_ring_mgr`

## Requirements
- R1: After reset the transmit index is 0, the receive index and the boundary are 0x40, and tx_start, tx_busy, rx_ok, tx_irq and rx_irq are all low.
- R2: The host port decodes only the low 10 bits of host_addr, with word select from bits [9:2]. Descriptor n has its flags word at byte 8n and its buffer pointer at 8n+4. The flags word carries the length in [31:16], ownership in bit 15, interrupt request in bit 14, wrap in bit 13, transmit pad in bit 12 and the receive miss flag in bit 7. host_rdata returns the addressed word one cycle after the address is presented.
- R3: A transmission starts only when a pending evaluation finds transmit enabled, a nonzero boundary, ownership set in the current transmit descriptor and a length above 4. tx_start is then a one-cycle pulse, with tx_len, tx_ptr and tx_pad taken from that descriptor.
- R4: A start evaluation is requested by any host descriptor write, and it is carried out in the next cycle. A rising tx_en also requests one. Completion of a transmission does not request one.
- R5: On transmit completion the flags word keeps its length and bits 14 to 9, and clears bit 15 and bits 8 to 0.
- R6: After transmit completion the index goes to 0 if wrap is set. Otherwise it increments, and it returns to 0 when it reaches the boundary.
- R7: rx_ok is high only when rx_en is high in this cycle and in the previous one, the boundary is below 0x80, and the current receive descriptor has ownership set.
- R8: On receive completion the length field takes rx_len, bit 15 and bits 8 to 0 are cleared, bit 7 takes rx_miss, and bits 14 to 9 are kept.
- R9: After receive completion the index goes to the boundary if wrap is set or the index is 127. Otherwise it increments.
- R10: tx_irq or rx_irq pulses for one cycle, the cycle after a completion, when the completed descriptor has bit 14 set.
- R11: A rising rx_en loads the receive index with the boundary. A rising tx_en, while idle, sets the transmit index to 0.
- R12: tx_done while no transmission is active, and rx_done while rx_ok is low, change no descriptor, index or interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host byte address (low 10 bits decoded) |
| host_we | input | 1 | Host word write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| bnd_we | input | 1 | Boundary write strobe |
| bnd_wdata | input | 8 | New boundary value |
| boundary | output | 8 | Current boundary |
| tx_en | input | 1 | Transmit enable |
| tx_done | input | 1 | Transmit completion pulse |
| tx_start | output | 1 | Transmit start pulse |
| tx_len | output | 16 | Length of the started frame |
| tx_ptr | output | 32 | Buffer pointer of the started frame |
| tx_pad | output | 1 | Pad request of the started frame |
| tx_busy | output | 1 | Transmission in progress |
| tx_idx | output | 7 | Current transmit descriptor |
| tx_irq | output | 1 | Transmit interrupt request pulse |
| rx_en | input | 1 | Receive enable |
| rx_done | input | 1 | Receive completion pulse |
| rx_len | input | 16 | Received frame length |
| rx_miss | input | 1 | Address filter miss for the received frame |
| rx_ok | output | 1 | A frame may be accepted |
| rx_ptr | output | 32 | Buffer pointer of the current receive descriptor |
| rx_idx | output | 7 | Current receive descriptor |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
The rule that sends the receive index back to the boundary from entry 127 is hard to reach, because the ring normally needs dozens of receptions to get there. The bench moves the boundary to 0x7E before it enables reception, so that two receptions cross entry 127. A second hard case is the rule that completion alone starts nothing. Here the bench prepares the next transmit descriptor before the first one starts, watches that no start appears after completion, and then triggers one with an unrelated host write.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;

    localparam int LEN_LSB  = 16;
    localparam int MISS_BIT = 7;

    typedef struct packed {
        logic [15:0] len;
        logic        own;
        logic        irq;
        logic        wrap;
        logic        pad;
        logic [11:0] low;
    } bd_flags_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_BUSY = 1'b1
    } tx_state_t;

    function automatic bd_flags_t tx_retire(bd_flags_t f);
        bd_flags_t r;
        r          = f;
        r.own      = 1'b0;
        r.low[8:0] = '0;
        return r;
    endfunction

    function automatic bd_flags_t rx_retire(bd_flags_t f, logic [15:0] len, logic miss);
        bd_flags_t r;
        r               = f;
        r.len           = len;
        r.own           = 1'b0;
        r.low[8:0]      = '0;
        r.low[MISS_BIT] = miss;
        return r;
    endfunction

endpackage

// File: rtl/bd_store.sv
module bd_store
    import bd_ring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    parameter int HOST_AW  = 16,
    localparam int IDX_W   = $clog2(NUM_DESC),
    localparam int WA_W    = IDX_W + 1
) (
    input  logic               clk,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_we,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic [IDX_W-1:0]   tx_idx,
    output bd_flags_t          tx_flags,
    output logic [31:0]        tx_ptr,
    input  logic [IDX_W-1:0]   rx_idx,
    output bd_flags_t          rx_flags,
    output logic [31:0]        rx_ptr,
    input  logic               txwb_en,
    input  logic [IDX_W-1:0]   txwb_idx,
    input  bd_flags_t          txwb_flags,
    input  logic               rxwb_en,
    input  logic [IDX_W-1:0]   rxwb_idx,
    input  bd_flags_t          rxwb_flags
);
    localparam int WORDS = 2 * NUM_DESC;

    logic [31:0]     mem [WORDS];
    logic [WA_W-1:0] host_word;
    logic            unused_host;

    assign host_word   = host_addr[WA_W+1:2];
    assign unused_host = ^{host_addr[HOST_AW-1:WA_W+2], host_addr[1:0]};

    assign tx_flags = bd_flags_t'(mem[{tx_idx, 1'b0}]);
    assign tx_ptr   = mem[{tx_idx, 1'b1}];
    assign rx_flags = bd_flags_t'(mem[{rx_idx, 1'b0}]);
    assign rx_ptr   = mem[{rx_idx, 1'b1}];

    always_ff @(posedge clk) begin
        if (host_we)
            mem[host_word] <= host_wdata;
        if (txwb_en)
            mem[{txwb_idx, 1'b0}] <= txwb_flags;
        if (rxwb_en)
            mem[{rxwb_idx, 1'b0}] <= rxwb_flags;
        host_rdata <= mem[host_word];
    end

endmodule

// File: rtl/bd_tx_ctl.sv
module bd_tx_ctl
    import bd_ring_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic [IDX_W:0]   bnd,
    input  bd_flags_t        cur_flags,
    input  logic [31:0]      cur_ptr,
    input  logic             trig,
    input  logic             tx_done,
    output logic [IDX_W-1:0] tx_idx,
    output logic             tx_start,
    output logic [15:0]      tx_len,
    output logic [31:0]      tx_ptr,
    output logic             tx_pad,
    output logic             tx_busy,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output bd_flags_t        wb_flags,
    output logic             tx_irq
);
    tx_state_t        state;
    logic             en_q;
    logic             pend;
    logic             rise;
    logic             go;
    logic             fin;
    logic [IDX_W:0]   inc;
    logic [IDX_W-1:0] next_idx;

    assign rise = tx_en & ~en_q;
    assign go   = (state == TX_IDLE) & pend & ~rise & tx_en & (bnd != '0)
                & cur_flags.own & (cur_flags.len > 16'd4);
    assign fin  = (state == TX_BUSY) & tx_done;

    always_comb begin
        inc = {1'b0, tx_idx} + 1'b1;
        if (cur_flags.wrap || inc >= bnd)
            next_idx = '0;
        else
            next_idx = inc[IDX_W-1:0];
    end

    assign wb_en    = fin;
    assign wb_idx   = tx_idx;
    assign wb_flags = tx_retire(cur_flags);
    assign tx_busy  = (state == TX_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            en_q     <= 1'b0;
            pend     <= 1'b0;
            tx_idx   <= '0;
            tx_start <= 1'b0;
            tx_len   <= '0;
            tx_ptr   <= '0;
            tx_pad   <= 1'b0;
            tx_irq   <= 1'b0;
        end else begin
            en_q     <= tx_en;
            tx_start <= 1'b0;
            tx_irq   <= 1'b0;
            if (trig || rise)
                pend <= 1'b1;
            else if (state == TX_IDLE)
                pend <= 1'b0;
            if (rise && state == TX_IDLE)
                tx_idx <= '0;
            if (go) begin
                state    <= TX_BUSY;
                tx_start <= 1'b1;
                tx_len   <= cur_flags.len;
                tx_ptr   <= cur_ptr;
                tx_pad   <= cur_flags.pad;
            end
            if (fin) begin
                state  <= TX_IDLE;
                tx_idx <= next_idx;
                tx_irq <= cur_flags.irq;
            end
        end
    end

endmodule

// File: rtl/bd_rx_ctl.sv
module bd_rx_ctl
    import bd_ring_pkg::*;
#(
    parameter int IDX_W   = 7,
    parameter int BND_RST = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic [IDX_W:0]   bnd,
    input  bd_flags_t        cur_flags,
    input  logic             rx_done,
    input  logic [15:0]      rx_len,
    input  logic             rx_miss,
    output logic [IDX_W-1:0] rx_idx,
    output logic             rx_ok,
    output logic             wb_en,
    output bd_flags_t        wb_flags,
    output logic             rx_irq
);
    localparam logic [IDX_W:0] RST_B = IDX_W'(BND_RST);

    logic             en_q;
    logic             rise;
    logic             fin;
    logic [IDX_W-1:0] next_idx;

    assign rise  = rx_en & ~en_q;
    assign rx_ok = rx_en & en_q & ~bnd[IDX_W] & cur_flags.own;
    assign fin   = rx_done & rx_ok;

    always_comb begin
        if (cur_flags.wrap || rx_idx == '1)
            next_idx = bnd[IDX_W-1:0];
        else
            next_idx = rx_idx + 1'b1;
    end

    assign wb_en    = fin;
    assign wb_flags = rx_retire(cur_flags, rx_len, rx_miss);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            rx_idx <= RST_B[IDX_W-1:0];
            rx_irq <= 1'b0;
        end else begin
            en_q   <= rx_en;
            rx_irq <= fin & cur_flags.irq;
            if (rise)
                rx_idx <= bnd[IDX_W-1:0];
            else if (fin)
                rx_idx <= next_idx;
        end
    end

endmodule

// File: rtl/bd_ring_mgr.sv
module bd_ring_mgr
    import bd_ring_pkg::*;
#(
    parameter int NUM_DESC = 128,
    parameter int HOST_AW  = 16,
    parameter int BND_RST  = 64,
    localparam int IDX_W   = $clog2(NUM_DESC),
    localparam int BND_W   = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_we,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic               bnd_we,
    input  logic [BND_W-1:0]   bnd_wdata,
    output logic [BND_W-1:0]   boundary,
    input  logic               tx_en,
    input  logic               tx_done,
    output logic               tx_start,
    output logic [15:0]        tx_len,
    output logic [31:0]        tx_ptr,
    output logic               tx_pad,
    output logic               tx_busy,
    output logic [IDX_W-1:0]   tx_idx,
    output logic               tx_irq,
    input  logic               rx_en,
    input  logic               rx_done,
    input  logic [15:0]        rx_len,
    input  logic               rx_miss,
    output logic               rx_ok,
    output logic [31:0]        rx_ptr,
    output logic [IDX_W-1:0]   rx_idx,
    output logic               rx_irq
);
    bd_flags_t        tx_flags;
    bd_flags_t        rx_flags;
    logic [31:0]      tx_cur_ptr;
    logic             txwb_en;
    logic [IDX_W-1:0] txwb_idx;
    bd_flags_t        txwb_flags;
    logic             rxwb_en;
    bd_flags_t        rxwb_flags;

    always_ff @(posedge clk) begin
        if (rst)
            boundary <= BND_W'(BND_RST);
        else if (bnd_we)
            boundary <= bnd_wdata;
    end

    bd_store #(.NUM_DESC(NUM_DESC), .HOST_AW(HOST_AW)) u_store (
        .clk        (clk),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tx_idx     (tx_idx),
        .tx_flags   (tx_flags),
        .tx_ptr     (tx_cur_ptr),
        .rx_idx     (rx_idx),
        .rx_flags   (rx_flags),
        .rx_ptr     (rx_ptr),
        .txwb_en    (txwb_en),
        .txwb_idx   (txwb_idx),
        .txwb_flags (txwb_flags),
        .rxwb_en    (rxwb_en),
        .rxwb_idx   (rx_idx),
        .rxwb_flags (rxwb_flags)
    );

    bd_tx_ctl #(.IDX_W(IDX_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .bnd       (boundary),
        .cur_flags (tx_flags),
        .cur_ptr   (tx_cur_ptr),
        .trig      (host_we),
        .tx_done   (tx_done),
        .tx_idx    (tx_idx),
        .tx_start  (tx_start),
        .tx_len    (tx_len),
        .tx_ptr    (tx_ptr),
        .tx_pad    (tx_pad),
        .tx_busy   (tx_busy),
        .wb_en     (txwb_en),
        .wb_idx    (txwb_idx),
        .wb_flags  (txwb_flags),
        .tx_irq    (tx_irq)
    );

    bd_rx_ctl #(.IDX_W(IDX_W), .BND_RST(BND_RST)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .bnd       (boundary),
        .cur_flags (rx_flags),
        .rx_done   (rx_done),
        .rx_len    (rx_len),
        .rx_miss   (rx_miss),
        .rx_idx    (rx_idx),
        .rx_ok     (rx_ok),
        .wb_en     (rxwb_en),
        .wb_flags  (rxwb_flags),
        .rx_irq    (rx_irq)
    );

endmodule

// File: rtl/bd_ring_mgr_chk.sv
module bd_ring_mgr_chk #(
    parameter int IDX_W = 7,
    parameter int BND_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [BND_W-1:0] boundary,
    input logic             tx_en,
    input logic             tx_done,
    input logic             tx_start,
    input logic             tx_busy,
    input logic [IDX_W-1:0] tx_idx,
    input logic             tx_irq,
    input logic             rx_en,
    input logic             rx_done,
    input logic             rx_ok,
    input logic [IDX_W-1:0] rx_idx,
    input logic             rx_irq
);
    assert_start_gate_R3: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> ($past(tx_en) && $past(boundary) != '0));

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    assert_tx_advance_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && tx_done) |=> (tx_idx == '0 || tx_idx == $past(tx_idx) + 1'b1));

    assert_rx_gate_R7: assert property (@(posedge clk) disable iff (rst)
        rx_ok |-> (rx_en && !boundary[BND_W-1]));

    assert_rx_last_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && rx_done && rx_idx == '1) |=> rx_idx == $past(boundary[IDX_W-1:0]));

    assert_tx_irq_R10: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> $past(tx_busy && tx_done));

    assert_rx_irq_R10: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> $past(rx_ok && rx_done));

    assert_rx_reload_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_en) |=> rx_idx == $past(boundary[IDX_W-1:0]));

endmodule

bind bd_ring_mgr bd_ring_mgr_chk #(.IDX_W(IDX_W), .BND_W(BND_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .boundary (boundary),
    .tx_en    (tx_en),
    .tx_done  (tx_done),
    .tx_start (tx_start),
    .tx_busy  (tx_busy),
    .tx_idx   (tx_idx),
    .tx_irq   (tx_irq),
    .rx_en    (rx_en),
    .rx_done  (rx_done),
    .rx_ok    (rx_ok),
    .rx_idx   (rx_idx),
    .rx_irq   (rx_irq)
);

// File: tb/bd_ring_mgr_bench.sv
module bd_ring_mgr_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] host_addr;
    logic        host_we;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        bnd_we;
    logic [7:0]  bnd_wdata;
    logic [7:0]  boundary;
    logic        tx_en, tx_done, tx_start, tx_pad, tx_busy, tx_irq;
    logic [15:0] tx_len;
    logic [31:0] tx_ptr;
    logic [6:0]  tx_idx;
    logic        rx_en, rx_done, rx_miss, rx_ok, rx_irq;
    logic [15:0] rx_len;
    logic [31:0] rx_ptr;
    logic [6:0]  rx_idx;

    int checks = 0;
    int errors = 0;
    bit over   = 1'b0;

    always #2.5 clk = ~clk;

    bd_ring_mgr u_bd_ring_mgr (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bnd_we(bnd_we), .bnd_wdata(bnd_wdata), .boundary(boundary),
        .tx_en(tx_en), .tx_done(tx_done), .tx_start(tx_start), .tx_len(tx_len),
        .tx_ptr(tx_ptr), .tx_pad(tx_pad), .tx_busy(tx_busy), .tx_idx(tx_idx), .tx_irq(tx_irq),
        .rx_en(rx_en), .rx_done(rx_done), .rx_len(rx_len), .rx_miss(rx_miss),
        .rx_ok(rx_ok), .rx_ptr(rx_ptr), .rx_idx(rx_idx), .rx_irq(rx_irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(logic [15:0] a, logic [31:0] d);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(logic [15:0] a, output logic [31:0] d);
        host_addr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic bnd_wr(logic [7:0] v);
        bnd_wdata = v; bnd_we = 1'b1;
        @(negedge clk);
        bnd_we = 1'b0;
    endtask

    task automatic tx_finish();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic rx_finish(logic [15:0] l, logic m);
        rx_len = l; rx_miss = m; rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic expect_start(string tag, logic [15:0] l, logic [31:0] p, logic pd);
        @(negedge clk);
        chk({tag, " start"}, {31'd0, tx_start}, 32'd1);
        chk({tag, " len"}, {16'd0, tx_len}, {16'd0, l});
        chk({tag, " ptr"}, tx_ptr, p);
        chk({tag, " pad"}, {31'd0, tx_pad}, {31'd0, pd});
    endtask

    task automatic expect_quiet(string tag, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, {31'd0, tx_start}, 32'd0);
        end
    endtask

    task automatic t_reset();
        chk("R1 tx_idx", {25'd0, tx_idx}, 32'd0);
        chk("R1 rx_idx", {25'd0, rx_idx}, 32'h40);
        chk("R1 boundary", {24'd0, boundary}, 32'h40);
        chk("R1 outputs", {27'd0, tx_start, tx_busy, rx_ok, tx_irq, rx_irq}, 32'd0);
    endtask

    task automatic t_host_port();
        logic [31:0] d;
        host_wr(16'h1028, 32'hDEAD_BEEF);
        host_wr(16'h002C, 32'h1234_5678);
        host_rd(16'h0028, d);
        chk("R2 masked write", d, 32'hDEAD_BEEF);
        host_rd(16'hF02C, d);
        chk("R2 masked read", d, 32'h1234_5678);
    endtask

    task automatic t_tx_flow();
        logic [31:0] d;
        bnd_wr(8'd3);
        host_wr(16'h000C, 32'h0000_2000);
        host_wr(16'h0008, {16'd100, 16'h80F0});
        host_wr(16'h0014, 32'h0000_3000);
        host_wr(16'h0010, {16'd5, 16'h8000});
        host_wr(16'h0004, 32'h0000_1000);
        host_wr(16'h0000, {16'd60, 16'hD9FF});
        expect_quiet("R3 disabled no start", 2);
        tx_en = 1'b1;
        @(negedge clk);
        expect_start("R11 R3 enable d0", 16'd60, 32'h1000, 1'b1);
        @(negedge clk);
        chk("R3 single pulse", {30'd0, tx_start, tx_busy}, 32'd1);
        tx_finish();
        chk("R10 tx irq", {31'd0, tx_irq}, 32'd1);
        chk("R6 idx inc", {25'd0, tx_idx}, 32'd1);
        chk("R12 busy drop", {31'd0, tx_busy}, 32'd0);
        host_rd(16'h0000, d);
        chk("R5 retire d0", d, {16'd60, 16'h5800});
        chk("R10 irq single", {31'd0, tx_irq}, 32'd0);
        expect_quiet("R4 no start after done", 3);
        host_wr(16'h0050, 32'd0);
        expect_start("R4 trigger d1", 16'd100, 32'h2000, 1'b0);
        tx_finish();
        chk("R10 no irq", {31'd0, tx_irq}, 32'd0);
        chk("R6 idx 2", {25'd0, tx_idx}, 32'd2);
        host_rd(16'h0008, d);
        chk("R5 retire d1", d, {16'd100, 16'h0000});
        host_wr(16'h0054, 32'd0);
        expect_start("R3 len5", 16'd5, 32'h3000, 1'b0);
        tx_finish();
        chk("R6 boundary return", {25'd0, tx_idx}, 32'd0);
    endtask

    task automatic t_tx_limits();
        logic [31:0] d;
        host_wr(16'h0000, {16'd8, 16'hA000});
        expect_start("R6 wrap start", 16'd8, 32'h1000, 1'b0);
        tx_finish();
        chk("R6 wrap to 0", {25'd0, tx_idx}, 32'd0);
        host_wr(16'h0000, {16'd4, 16'h8000});
        expect_quiet("R3 len4 no start", 3);
        bnd_wr(8'd0);
        host_wr(16'h0000, {16'd60, 16'h8000});
        expect_quiet("R3 zero boundary", 3);
        bnd_wr(8'd3);
        host_wr(16'h0004, 32'h0000_1000);
        expect_start("R3 restored", 16'd60, 32'h1000, 1'b0);
        tx_finish();
        chk("R6 idx 1", {25'd0, tx_idx}, 32'd1);
        tx_finish();
        chk("R12 stray done idx", {25'd0, tx_idx}, 32'd1);
        chk("R12 stray done irq", {31'd0, tx_irq}, 32'd0);
        host_rd(16'h0008, d);
        chk("R12 stray done desc", d, {16'd100, 16'h0000});
        tx_en = 1'b0;
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        chk("R11 tx idx zero", {25'd0, tx_idx}, 32'd0);
        @(negedge clk);
        chk("R3 retired d0 no start", {31'd0, tx_start}, 32'd0);
    endtask

    task automatic t_rx_flow();
        logic [31:0] d;
        bnd_wr(8'h7E);
        host_wr(16'h03F4, 32'h0000_4000);
        host_wr(16'h03F0, {16'd0, 16'hC1FF});
        host_wr(16'h03FC, 32'h0000_5000);
        host_wr(16'h03F8, {16'd0, 16'h8000});
        chk("R7 disabled", {31'd0, rx_ok}, 32'd0);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R11 rx reload", {25'd0, rx_idx}, 32'd126);
        chk("R7 accept", {31'd0, rx_ok}, 32'd1);
        chk("R7 ptr", rx_ptr, 32'h4000);
        rx_finish(16'd70, 1'b1);
        chk("R10 rx irq", {31'd0, rx_irq}, 32'd1);
        chk("R9 inc", {25'd0, rx_idx}, 32'd127);
        chk("R7 next ptr", rx_ptr, 32'h5000);
        host_rd(16'h03F0, d);
        chk("R8 retire miss", d, {16'd70, 16'h4080});
        rx_finish(16'd1500, 1'b0);
        chk("R10 rx no irq", {31'd0, rx_irq}, 32'd0);
        chk("R9 last entry", {25'd0, rx_idx}, 32'd126);
        chk("R7 not empty", {31'd0, rx_ok}, 32'd0);
        host_rd(16'h03F8, d);
        chk("R8 retire hit", d, {16'd1500, 16'h0000});
        rx_finish(16'd9, 1'b1);
        chk("R12 stray rx idx", {25'd0, rx_idx}, 32'd126);
        chk("R12 stray rx irq", {31'd0, rx_irq}, 32'd0);
        host_rd(16'h03F0, d);
        chk("R12 stray rx desc", d, {16'd70, 16'h4080});
    endtask

    task automatic t_rx_limits();
        bnd_wr(8'h40);
        rx_en = 1'b0;
        @(negedge clk);
        host_wr(16'h0200, {16'd0, 16'hA000});
        rx_en = 1'b1;
        @(negedge clk);
        chk("R11 reload 64", {25'd0, rx_idx}, 32'd64);
        chk("R7 ok 64", {31'd0, rx_ok}, 32'd1);
        rx_finish(16'd64, 1'b0);
        chk("R9 wrap", {25'd0, rx_idx}, 32'd64);
        host_wr(16'h0200, {16'd0, 16'h8000});
        chk("R7 refilled", {31'd0, rx_ok}, 32'd1);
        bnd_wr(8'h80);
        chk("R7 boundary 0x80", {31'd0, rx_ok}, 32'd0);
        bnd_wr(8'h40);
        chk("R7 boundary back", {31'd0, rx_ok}, 32'd1);
        rx_finish(16'd64, 1'b0);
        chk("R9 plain inc", {25'd0, rx_idx}, 32'd65);
    endtask

    initial begin
        rst = 1'b1;
        host_addr = '0; host_we = 1'b0; host_wdata = '0;
        bnd_we = 1'b0; bnd_wdata = '0;
        tx_en = 1'b0; tx_done = 1'b0;
        rx_en = 1'b0; rx_done = 1'b0; rx_len = '0; rx_miss = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_host_port();
        t_tx_flow();
        t_tx_limits();
        t_rx_flow();
        t_rx_limits();
        if (!over) begin
            over = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!over) begin
            over = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule